// File: doc/BRIEF.md
# Word LFSR with Nonlinear Finite-State Update

This core holds the running state of a word-oriented stream cipher: ten 32-bit shift-register stages, S0 (oldest) to S9 (newest), and two 32-bit nonlinear registers, R1 and R2, for 384 bits of state in all. On each enabled clock the register shifts down by one word and takes in a new top word. That word is formed from S9, S3 and S0, with S3 and S0 first multiplied by fixed field constants. In the same clock, R1 and R2 are updated from the register taps and from each other.

Both outputs are combinational views of the current state and describe the step that the next enabled edge will commit. The outgoing word is the present S0. The nonlinear output word is built from S9 and the new R1 and R2 values. A separate initializer writes all twelve words in one cycle through the load input. The output substitution stage, key and IV setup, and the keystream XOR are not part of this block.

Top module: `word_lfsr_fsm`

## Requirements
- R1: While rst_ni is low, all stages and both registers are cleared asynchronously, so s0_o and fsm_o both read 0.
- R2: On an enabled step, each stage takes the value of the stage above it (Si gets Si+1), and S9 gets S9 XOR mulinv(S3) XOR mul(S0). s0_o always shows the current S0.
- R3: The multipliers work over GF(2^8) with reduction polynomial 0x1A9 and generator b = 0x02. mul(x) is (x << 8) XOR T[x[31:24]]. Bytes 3..0 of T[v] are v·b^23, v·b^245, v·b^48, v·b^239. mulinv(x) is (x >> 8) XOR U[x[7:0]]. Bytes 3..0 of U[v] are v·b^16, v·b^39, v·b^6, v·b^64.
- R4: The R1 addend comes from a multiplexer steered by bit 0 of the current R1. When that bit is 1 the addend is S1 XOR S8; when it is 0 the addend is S1. Both words are read before the shift.
- R5: On a step, the new R1 is the current R2 plus the selected addend, modulo 2^32.
- R6: On a step, the new R2 is the current R1 multiplied by 0x54655307 modulo 2^32, then rotated left by 7.
- R7: fsm_o equals (S9 + new R1 mod 2^32) XOR new R2, computed from the current state without waiting for a clock.
- R8: When load_i is high at an edge, Si takes ld_s_i[32i+31:32i] for i = 0..9, R1 takes ld_r1_i and R2 takes ld_r2_i. This happens whatever the value of step_i.
- R9: When step_i and load_i are both low at an edge, all state holds, and s0_o and fsm_o keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Write all twelve words from the load ports |
| step_i | input | 1 | Advance state by one step |
| ld_s_i | input | 320 | Stage load words, S0 in the low word |
| ld_r1_i | input | 32 | R1 load value |
| ld_r2_i | input | 32 | R2 load value |
| s0_o | output | 32 | Current S0 (word leaving on the next step) |
| fsm_o | output | 32 | Nonlinear output word of the pending step |

## Verification
The core is loaded with several patterns and then stepped for long runs, with both outputs compared against an arithmetic model on every cycle. An all-zero load checks that the zero state is a fixed point. A single set bit in S0 or S3 drives only one multiplier lane, so it isolates the multiplication tables. R1 loads with bit 0 set and with bit 0 clear pick each input of the addend multiplexer. Pseudo-random loads mix all of these, and idle cycles and a load issued together with a step separate holding from stepping from overwriting.

// File: rtl/word_lfsr_pkg.sv
package word_lfsr_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned N_STAGES = 10;
  localparam logic [7:0]  GF_RED   = 8'hA9;  // low byte of 0x1A9
  localparam logic [31:0] TRANS_M  = 32'h5465_5307;
  localparam int unsigned TRANS_ROT = 7;

  typedef logic [WORD_W-1:0] word_t;

  function automatic logic [7:0] gf_xtime(input logic [7:0] b);
    return {b[6:0], 1'b0} ^ (b[7] ? GF_RED : 8'h00);
  endfunction

  function automatic logic [7:0] gf_pow(input int unsigned k);
    logic [7:0] acc;
    acc = 8'h01;
    for (int unsigned i = 0; i < k; i++) acc = gf_xtime(acc);
    return acc;
  endfunction

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] c);
    logic [7:0] acc, sh;
    acc = 8'h00;
    sh  = a;
    for (int i = 0; i < 8; i++) begin
      if (c[i]) acc = acc ^ sh;
      sh = gf_xtime(sh);
    end
    return acc;
  endfunction

  function automatic word_t trans(input word_t x);
    word_t p;
    p = x * TRANS_M;
    return (p << TRANS_ROT) | (p >> (WORD_W - TRANS_ROT));
  endfunction
endpackage

// File: rtl/word_alpha_mul.sv
module word_alpha_mul
  import word_lfsr_pkg::*;
#(
  parameter bit INVERSE = 1'b0
) (
  input  word_t x_i,
  output word_t y_o
);
  localparam int unsigned LANES = WORD_W / 8;
  // exponents of b per byte lane, lane 3 first
  localparam int unsigned EXP_F [LANES] = '{23, 245, 48, 239};
  localparam int unsigned EXP_R [LANES] = '{16, 39, 6, 64};

  logic [7:0] idx;
  word_t      tbl;

  generate
    if (INVERSE) begin : g_inv
      assign idx = x_i[7:0];
      for (genvar l = 0; l < LANES; l++) begin : g_lane
        localparam logic [7:0] C = gf_pow(EXP_R[LANES-1-l]);
        assign tbl[8*l +: 8] = gf_mul(idx, C);
      end
      assign y_o = (x_i >> 8) ^ tbl;
    end else begin : g_fwd
      assign idx = x_i[WORD_W-1 -: 8];
      for (genvar l = 0; l < LANES; l++) begin : g_lane
        localparam logic [7:0] C = gf_pow(EXP_F[LANES-1-l]);
        assign tbl[8*l +: 8] = gf_mul(idx, C);
      end
      assign y_o = (x_i << 8) ^ tbl;
    end
  endgenerate
endmodule

// File: rtl/word_lfsr_reg.sv
module word_lfsr_reg
  import word_lfsr_pkg::*;
(
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       load_i,
  input  logic                       step_i,
  input  logic [N_STAGES*WORD_W-1:0] ld_s_i,
  output word_t                      s0_o,
  output word_t                      s1_o,
  output word_t                      s8_o,
  output word_t                      s9_o
);
  localparam int unsigned TOP = N_STAGES - 1;

  word_t st_q [N_STAGES];
  word_t a_s0, ai_s3, fb;

  word_alpha_mul #(.INVERSE(1'b0)) u_mul_a  (.x_i(st_q[0]), .y_o(a_s0));
  word_alpha_mul #(.INVERSE(1'b1)) u_mul_ai (.x_i(st_q[3]), .y_o(ai_s3));

  assign fb = st_q[TOP] ^ ai_s3 ^ a_s0;

  generate
    for (genvar i = 0; i < N_STAGES; i++) begin : g_st
      word_t nxt;
      if (i == TOP) begin : g_top
        assign nxt = fb;
      end else begin : g_mid
        assign nxt = st_q[i+1];
      end
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     st_q[i] <= '0;
        else if (load_i) st_q[i] <= ld_s_i[WORD_W*i +: WORD_W];
        else if (step_i) st_q[i] <= nxt;
      end
    end
  endgenerate

  assign s0_o = st_q[0];
  assign s1_o = st_q[1];
  assign s8_o = st_q[8];
  assign s9_o = st_q[TOP];

  p_shift_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i) |=> st_q[0] == $past(st_q[1]));
  p_fb_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i) |=> st_q[TOP] == ($past(st_q[TOP]) ^ $past(ai_s3) ^ $past(a_s0)));
endmodule

// File: rtl/word_fsm_core.sv
module word_fsm_core
  import word_lfsr_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  load_i,
  input  logic  step_i,
  input  word_t ld_r1_i,
  input  word_t ld_r2_i,
  input  word_t s1_i,
  input  word_t s8_i,
  input  word_t s9_i,
  output word_t fsm_o
);
  word_t r1_q, r2_q, addend, r1_d, r2_d;

  assign addend = r1_q[0] ? (s1_i ^ s8_i) : s1_i;
  assign r1_d   = r2_q + addend;
  assign r2_d   = trans(r1_q);
  assign fsm_o  = (s9_i + r1_d) ^ r2_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      r1_q <= '0;
      r2_q <= '0;
    end else if (load_i) begin
      r1_q <= ld_r1_i;
      r2_q <= ld_r2_i;
    end else if (step_i) begin
      r1_q <= r1_d;
      r2_q <= r2_d;
    end
  end

  p_r1_sel_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i && !r1_q[0]) |=> r1_q == $past(r2_q) + $past(s1_i));
  p_r1_add_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i && r1_q[0]) |=> r1_q == $past(r2_q) + ($past(s1_i) ^ $past(s8_i)));
  p_r2_trans_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i) |=> r2_q == trans($past(r1_q)));
endmodule

// File: rtl/word_lfsr_fsm.sv
module word_lfsr_fsm
  import word_lfsr_pkg::*;
(
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       load_i,
  input  logic                       step_i,
  input  logic [N_STAGES*WORD_W-1:0] ld_s_i,
  input  logic [WORD_W-1:0]          ld_r1_i,
  input  logic [WORD_W-1:0]          ld_r2_i,
  output logic [WORD_W-1:0]          s0_o,
  output logic [WORD_W-1:0]          fsm_o
);
  word_t s1, s8, s9;

  word_lfsr_reg u_reg (
    .clk_i, .rst_ni, .load_i, .step_i, .ld_s_i,
    .s0_o, .s1_o(s1), .s8_o(s8), .s9_o(s9)
  );

  word_fsm_core u_fsm (
    .clk_i, .rst_ni, .load_i, .step_i, .ld_r1_i, .ld_r2_i,
    .s1_i(s1), .s8_i(s8), .s9_i(s9), .fsm_o
  );

  p_load_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> s0_o == $past(ld_s_i[WORD_W-1:0]));
  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !step_i) |=> ($stable(s0_o) && $stable(fsm_o)));
  p_out_shift_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i) |=> s0_o == $past(s1));
endmodule

// File: tb/word_lfsr_fsm_test.sv
module word_lfsr_fsm_test;
  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         load_i = 1'b0, step_i = 1'b0;
  logic [319:0] ld_s_i = '0;
  logic [31:0]  ld_r1_i = '0, ld_r2_i = '0;
  logic [31:0]  s0_o, fsm_o;

  int unsigned n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  logic [31:0] ms [10];
  logic [31:0] mr1, mr2;
  logic [31:0] tf [256];
  logic [31:0] tr [256];
  logic [31:0] seed = 32'h1234_5678;

  word_lfsr_fsm uut (.clk_i(clk), .rst_ni, .load_i, .step_i, .ld_s_i,
                     .ld_r1_i, .ld_r2_i, .s0_o, .fsm_o);

  always #4 clk = ~clk;

  function automatic logic [7:0] bmul(input logic [7:0] a, input logic [7:0] b);
    logic [15:0] p = '0;
    for (int i = 0; i < 8; i++) if (b[i]) p ^= 16'(a) << i;
    for (int i = 15; i >= 8; i--) if (p[i]) p ^= 16'h1A9 << (i - 8);
    return p[7:0];
  endfunction

  function automatic logic [7:0] bexp(input int k);
    logic [7:0] r = 8'h01;
    for (int i = 0; i < k; i++) r = bmul(r, 8'h02);
    return r;
  endfunction

  function automatic logic [31:0] rnd();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed;
  endfunction

  function automatic logic [31:0] exp_fsm();
    logic [31:0] n1, n2, p;
    n1 = mr2 + (mr1[0] ? (ms[1] ^ ms[8]) : ms[1]);
    p  = mr1 * 32'h5465_5307;
    n2 = {p[24:0], p[31:25]};
    return (ms[9] + n1) ^ n2;
  endfunction

  task automatic model_step();
    logic [31:0] n1, n2, p, fb;
    n1 = mr2 + (mr1[0] ? (ms[1] ^ ms[8]) : ms[1]);
    p  = mr1 * 32'h5465_5307;
    n2 = {p[24:0], p[31:25]};
    fb = ms[9] ^ ((ms[3] >> 8) ^ tr[ms[3][7:0]]) ^ ((ms[0] << 8) ^ tf[ms[0][31:24]]);
    for (int i = 0; i < 9; i++) ms[i] = ms[i+1];
    ms[9] = fb;
    mr1 = n1;
    mr2 = n2;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic chk_outs(input string req);
    chk({req, " s0"}, s0_o, ms[0]);
    chk({req, " fsm"}, fsm_o, exp_fsm());
  endtask

  // drive at negedge, commit at posedge, model follows
  task automatic cyc(input logic ld, input logic st);
    @(negedge clk);
    load_i = ld;
    step_i = st;
    @(posedge clk);
    if (ld) begin
      for (int i = 0; i < 10; i++) ms[i] = ld_s_i[32*i +: 32];
      mr1 = ld_r1_i;
      mr2 = ld_r2_i;
    end else if (st) model_step();
    @(negedge clk);
    load_i = 1'b0;
    step_i = 1'b0;
  endtask

  task automatic run(input string req, input int n);
    for (int k = 0; k < n; k++) begin
      cyc(1'b0, 1'b1);
      chk_outs(req);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    for (int v = 0; v < 256; v++) begin
      tf[v] = {bmul(8'(v), bexp(23)), bmul(8'(v), bexp(245)),
               bmul(8'(v), bexp(48)), bmul(8'(v), bexp(239))};
      tr[v] = {bmul(8'(v), bexp(16)), bmul(8'(v), bexp(39)),
               bmul(8'(v), bexp(6)),  bmul(8'(v), bexp(64))};
    end
    for (int i = 0; i < 10; i++) ms[i] = '0;
    mr1 = '0;
    mr2 = '0;

    // R1: reset state; zero state is a fixed point (R2, R7)
    repeat (3) @(negedge clk);
    chk("R1 s0", s0_o, 32'h0);
    chk("R1 fsm", fsm_o, 32'h0);
    rst_ni = 1'b1;
    run("R2 zero", 5);

    // R3: single bit in S0 lane then S3 lane, R1 lsb clear (R4)
    ld_s_i = '0;
    ld_s_i[31] = 1'b1;
    ld_s_i[3*32 + 0] = 1'b1;
    ld_r1_i = 32'h0000_0002;
    ld_r2_i = 32'h0;
    cyc(1'b1, 1'b0);
    chk_outs("R8 load");
    run("R3 lanes", 40);

    // R4/R5: R1 lsb set picks S1^S8
    for (int i = 0; i < 10; i++) ld_s_i[32*i +: 32] = 32'h0101_0101 * (i + 1);
    ld_r1_i = 32'hFFFF_FFFF;
    ld_r2_i = 32'h8000_0001;
    cyc(1'b1, 1'b0);
    chk_outs("R4 load");
    run("R5 carry", 40);

    // R6/R7: pseudo-random loads, long runs
    for (int p = 0; p < 8; p++) begin
      for (int i = 0; i < 10; i++) ld_s_i[32*i +: 32] = rnd();
      ld_r1_i = rnd();
      ld_r2_i = rnd();
      cyc(1'b1, 1'b0);
      chk_outs("R8 rand load");
      run("R7 rand", 300);
    end

    // R9: hold with both controls low
    for (int k = 0; k < 4; k++) begin
      cyc(1'b0, 1'b0);
      chk_outs("R9 hold");
    end
    run("R6 after hold", 5);

    // R8: load wins over step
    for (int i = 0; i < 10; i++) ld_s_i[32*i +: 32] = rnd();
    ld_r1_i = rnd();
    ld_r2_i = rnd();
    cyc(1'b1, 1'b1);
    chk_outs("R8 load over step");
    run("R2 post", 20);

    // R1: async reset mid-run
    @(negedge clk);
    rst_ni = 1'b0;
    #1;
    chk("R1 s0 mid", s0_o, 32'h0);
    chk("R1 fsm mid", fsm_o, 32'h0);
    finish_up();
  end
endmodule